// File: doc/BRIEF.md
# Power-Down Sequencer with Timed Oscillator Restart

This block decides, when the CPU asks to sleep, whether the chip merely gates the CPU clock or shuts down the oscillator and every clock. Once shut down, it watches a set of wake sources and brings the chip back along one of three paths. An interrupt wake restarts the oscillator and then waits a programmable settling time. A reset-pin wake restores all clocks at once and holds until the pin is released. A hardware-standby pin pulls the chip into a separate deep state that takes precedence over everything else.

All inputs are taken as synchronous to a free-running reference clock that keeps running while the oscillator is off or settling. The outputs are an oscillator enable, two clock-gate enables (CPU, peripherals), one-cycle requests for interrupt or reset exception handling, and a 3-bit mode code. The settling field selects 2^(8+code) reference cycles, which is 256 to 32768.

Top module: `pwrdn_seq`

## Requirements
- R1: From mode RUN (code 0), a `sleep_req` seen at a clock edge with `standby_en`=1 and `wdog_clk_sel`=0 moves the block to mode DEEP_STOP (code 2) at that edge. No other path reaches DEEP_STOP.
- R2: In DEEP_STOP and in HW_HOLD (code 5), `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0. In RUN all three are 1. During settling (code 3), `osc_en` is 1 and both clock enables are 0.
- R3: A `sleep_req` from RUN with `standby_en`=0, or with `wdog_clk_sel`=1, enters mode LIGHT_SLEEP (code 1). In this mode `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` are 1. Any interrupt wake (see R4, R6, R7) returns the block to RUN at the next edge, with no settling delay, and pulses `irq_exc_req`.
- R4: Line `irq_lines[n]` counts as a wake only when `irq_en[n]` is 1 and `irq_masked` is 0. A disabled or masked line leaves the block in DEEP_STOP.
- R5: An interrupt wake in DEEP_STOP enters mode SETTLE (code 3) and loads 2^(8+`settle_sel`). The block stays in SETTLE for exactly that many reference cycles, then enters RUN with a one-cycle `irq_exc_req`. Interrupt inputs have no effect while settling.
- R6: With `nmi_rise_sel`=0 only a falling edge of `nmi_pin` wakes the block. With `nmi_rise_sel`=1 only a rising edge wakes it. NMI is never masked.
- R7: `resume_wake` at 1 wakes the block like an enabled interrupt.
- R8: `ext_rst_n` low moves the block from any mode except HW_HOLD to RESET_WAIT (code 4) at the next edge, with all clocks and the oscillator on. The block stays there until `ext_rst_n` is high, then enters RUN with a one-cycle `rst_exc_req`. `irq_exc_req` stays 0 on that exit.
- R9: `hw_stdby_n` low moves the block to HW_HOLD at the next edge from any mode. This overrides a reset or interrupt wake presented in the same cycle.
- R10: HW_HOLD is left only when `hw_stdby_n` is high and `ext_rst_n` is low, which goes to RESET_WAIT. Any other combination keeps HW_HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset of the sequencer, active low, asynchronous |
| sleep_req | input | 1 | CPU sleep request, sampled in RUN |
| standby_en | input | 1 | 1 selects deep stop on sleep |
| wdog_clk_sel | input | 1 | Watchdog clock select; 1 blocks deep stop |
| settle_sel | input | 3 | Settling length code |
| irq_lines | input | 16 | Interrupt request lines |
| irq_en | input | 16 | Per-line wake enables |
| irq_masked | input | 1 | CPU interrupt mask |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_rise_sel | input | 1 | NMI edge select: 1 rising, 0 falling |
| resume_wake | input | 1 | Resume wake request |
| ext_rst_n | input | 1 | Reset pin, active low |
| hw_stdby_n | input | 1 | Hardware-standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| irq_exc_req | output | 1 | One-cycle request for interrupt exception handling |
| rst_exc_req | output | 1 | One-cycle request for reset exception handling |
| mode_o | output | 3 | Current mode code |

## Verification
Mode changes, clock enables and both request pulses are due one reference edge after the stimulus that causes them. The bench drives inputs one time unit after a rising edge and reads outputs one time unit after the next rising edge, so each result is read in the cycle it is first valid. Settling is measured by counting the reads that show mode 3, starting with the read right after the wake edge. That count must equal 2^(8+code) exactly, and the exception request must show on the first read in RUN and be gone on the read after it. Persistence cases, such as masked lines, the wrong NMI edge or HW_HOLD exits that are not allowed, are read two edges after the stimulus to show that nothing moved.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   typedef enum logic [2:0] {
      PM_RUN        = 3'd0,
      PM_LIGHT      = 3'd1,
      PM_DEEP       = 3'd2,
      PM_SETTLE     = 3'd3,
      PM_RESET_WAIT = 3'd4,
      PM_HW_HOLD    = 3'd5
   } pm_mode_e;

   localparam int PM_MODE_W = 3;

endpackage

// File: rtl/pwrdn_wake_detect.sv
module pwrdn_wake_detect #(
   parameter int IRQ_N = 16
) (
   input  logic             clk_ref,
   input  logic             por_n,
   input  logic [IRQ_N-1:0] irq_lines,
   input  logic [IRQ_N-1:0] irq_en,
   input  logic             irq_masked,
   input  logic             nmi_pin,
   input  logic             nmi_rise_sel,
   input  logic             resume_wake,
   output logic             wake_any
);

   logic [IRQ_N-1:0] line_ok;
   logic             irq_hit;
   logic             nmi_q;
   logic             nmi_hit;

   // per-line qualification by its own enable
   for (genvar g = 0; g < IRQ_N; g++) begin : g_line
      assign line_ok[g] = irq_lines[g] & irq_en[g];
   end

   assign irq_hit = (|line_ok) & ~irq_masked;

   always_ff @(posedge clk_ref or negedge por_n) begin
      if (!por_n) nmi_q <= 1'b0;
      else        nmi_q <= nmi_pin;
   end

   always_comb begin
      if (nmi_rise_sel) nmi_hit = nmi_pin & ~nmi_q;
      else              nmi_hit = ~nmi_pin & nmi_q;
   end

   assign wake_any = irq_hit | nmi_hit | resume_wake;

   // R4: masking suppresses all interrupt-line wakes
   a_r4_mask_blocks: assert property (@(posedge clk_ref) disable iff (!por_n)
      (irq_masked && !resume_wake && (nmi_pin == nmi_q)) |-> !wake_any);

endmodule

// File: rtl/pwrdn_settle_timer.sv
module pwrdn_settle_timer #(
   parameter int CODE_W    = 3,
   parameter int BASE_LOG2 = 8
) (
   input  logic              clk_ref,
   input  logic              por_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   input  logic              active,
   output logic              expire
);

   localparam int NCODES = 2 ** CODE_W;
   localparam int CNT_W  = BASE_LOG2 + NCODES;

   logic [CNT_W-1:0] len_tbl [NCODES];
   logic [CNT_W-1:0] cnt_q;

   // one load value per settling code: 2^(BASE_LOG2+code)
   for (genvar g = 0; g < NCODES; g++) begin : g_len
      assign len_tbl[g] = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + g);
   end

   always_ff @(posedge clk_ref or negedge por_n) begin
      if (!por_n)                          cnt_q <= '0;
      else if (load)                       cnt_q <= len_tbl[code];
      else if (active && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign expire = active && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

   // R5: a freshly loaded count never expires on the following cycle
   a_r5_no_instant_expire: assert property (@(posedge clk_ref) disable iff (!por_n)
      load |=> !expire);

   // R5: while settling the counter holds a live value
   a_r5_count_live: assert property (@(posedge clk_ref) disable iff (!por_n)
      (active && !$past(load)) |-> (cnt_q != '0));

endmodule

// File: rtl/pwrdn_mode_fsm.sv
module pwrdn_mode_fsm
   import pwrdn_pkg::*;
(
   input  logic     clk_ref,
   input  logic     por_n,
   input  logic     sleep_req,
   input  logic     standby_en,
   input  logic     wdog_clk_sel,
   input  logic     wake_any,
   input  logic     settle_done,
   input  logic     ext_rst_n,
   input  logic     hw_stdby_n,
   output pm_mode_e mode,
   output logic     settle_load,
   output logic     settle_active,
   output logic     irq_exc_req,
   output logic     rst_exc_req
);

   pm_mode_e mode_q, mode_d;
   logic     irq_req_q, rst_req_q;

   always_comb begin
      mode_d      = mode_q;
      settle_load = 1'b0;
      if (!hw_stdby_n) begin
         mode_d = PM_HW_HOLD;
      end else if (mode_q == PM_HW_HOLD) begin
         if (!ext_rst_n) mode_d = PM_RESET_WAIT;
      end else if (!ext_rst_n) begin
         mode_d = PM_RESET_WAIT;
      end else begin
         case (mode_q)
            PM_RUN: begin
               if (sleep_req) begin
                  if (standby_en && !wdog_clk_sel) mode_d = PM_DEEP;
                  else                             mode_d = PM_LIGHT;
               end
            end
            PM_LIGHT: begin
               if (wake_any) mode_d = PM_RUN;
            end
            PM_DEEP: begin
               if (wake_any) begin
                  mode_d      = PM_SETTLE;
                  settle_load = 1'b1;
               end
            end
            PM_SETTLE: begin
               if (settle_done) mode_d = PM_RUN;
            end
            PM_RESET_WAIT: begin
               mode_d = PM_RUN;
            end
            default: mode_d = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge clk_ref or negedge por_n) begin
      if (!por_n) begin
         mode_q    <= PM_RUN;
         irq_req_q <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         irq_req_q <= (mode_q == PM_LIGHT || mode_q == PM_SETTLE) && (mode_d == PM_RUN);
         rst_req_q <= (mode_q == PM_RESET_WAIT) && (mode_d == PM_RUN);
      end
   end

   assign mode          = mode_q;
   assign settle_active = (mode_q == PM_SETTLE);
   assign irq_exc_req   = irq_req_q;
   assign rst_exc_req   = rst_req_q;

   // R1: qualified sleep request enters deep stop
   a_r1_enter_deep: assert property (@(posedge clk_ref) disable iff (!por_n)
      (mode_q == PM_RUN && sleep_req && standby_en && !wdog_clk_sel && hw_stdby_n && ext_rst_n)
      |=> (mode_q == PM_DEEP));

   // R1: deep stop is only ever entered from RUN through a qualified request
   a_r1_only_path: assert property (@(posedge clk_ref) disable iff (!por_n)
      (mode_q == PM_DEEP && $past(mode_q) != PM_DEEP)
      |-> $past(mode_q == PM_RUN && sleep_req && standby_en && !wdog_clk_sel));

   // R4: without a wake the block stays in deep stop
   a_r4_hold_deep: assert property (@(posedge clk_ref) disable iff (!por_n)
      (mode_q == PM_DEEP && !wake_any && hw_stdby_n && ext_rst_n) |=> (mode_q == PM_DEEP));

   // R5: settling is left only on expiry or a pin override
   a_r5_hold_settle: assert property (@(posedge clk_ref) disable iff (!por_n)
      (mode_q == PM_SETTLE && !settle_done && hw_stdby_n && ext_rst_n) |=> (mode_q == PM_SETTLE));

   // R8: reset pin forces the clocked reset-wait mode
   a_r8_reset_wait: assert property (@(posedge clk_ref) disable iff (!por_n)
      (!ext_rst_n && hw_stdby_n) |=> (mode_q == PM_RESET_WAIT));

   // R9: hardware-standby pin wins over everything
   a_r9_hw_priority: assert property (@(posedge clk_ref) disable iff (!por_n)
      !hw_stdby_n |=> (mode_q == PM_HW_HOLD));

   // R10: only pin high with reset low leaves HW_HOLD
   a_r10_hw_exit: assert property (@(posedge clk_ref) disable iff (!por_n)
      (mode_q == PM_HW_HOLD && !(hw_stdby_n && !ext_rst_n)) |=> (mode_q == PM_HW_HOLD));

   // R8: the two exception requests never coincide and only appear in RUN
   a_r8_req_exclusive: assert property (@(posedge clk_ref) disable iff (!por_n)
      $onehot0({irq_req_q, rst_req_q}));

   a_r5_req_in_run: assert property (@(posedge clk_ref) disable iff (!por_n)
      (irq_req_q || rst_req_q) |-> (mode_q == PM_RUN));

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
   import pwrdn_pkg::*;
#(
   parameter int IRQ_N     = 16,
   parameter int CODE_W    = 3,
   parameter int BASE_LOG2 = 8
) (
   input  logic              clk_ref,
   input  logic              por_n,
   input  logic              sleep_req,
   input  logic              standby_en,
   input  logic              wdog_clk_sel,
   input  logic [CODE_W-1:0] settle_sel,
   input  logic [IRQ_N-1:0]  irq_lines,
   input  logic [IRQ_N-1:0]  irq_en,
   input  logic              irq_masked,
   input  logic              nmi_pin,
   input  logic              nmi_rise_sel,
   input  logic              resume_wake,
   input  logic              ext_rst_n,
   input  logic              hw_stdby_n,
   output logic              osc_en,
   output logic              cpu_clk_en,
   output logic              periph_clk_en,
   output logic              irq_exc_req,
   output logic              rst_exc_req,
   output logic [PM_MODE_W-1:0] mode_o
);

   initial begin
      assert (IRQ_N >= 1 && IRQ_N <= 64) else $error("IRQ_N out of range");
      assert (CODE_W >= 1 && CODE_W <= 4) else $error("CODE_W out of range");
      assert (BASE_LOG2 >= 1 && BASE_LOG2 <= 16) else $error("BASE_LOG2 out of range");
   end

   logic     wake_any;
   logic     settle_load, settle_active, settle_done;
   pm_mode_e mode;

   pwrdn_wake_detect #(.IRQ_N(IRQ_N)) u_wake (
      .clk_ref      (clk_ref),
      .por_n        (por_n),
      .irq_lines    (irq_lines),
      .irq_en       (irq_en),
      .irq_masked   (irq_masked),
      .nmi_pin      (nmi_pin),
      .nmi_rise_sel (nmi_rise_sel),
      .resume_wake  (resume_wake),
      .wake_any     (wake_any)
   );

   pwrdn_settle_timer #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)) u_timer (
      .clk_ref (clk_ref),
      .por_n   (por_n),
      .load    (settle_load),
      .code    (settle_sel),
      .active  (settle_active),
      .expire  (settle_done)
   );

   pwrdn_mode_fsm u_fsm (
      .clk_ref       (clk_ref),
      .por_n         (por_n),
      .sleep_req     (sleep_req),
      .standby_en    (standby_en),
      .wdog_clk_sel  (wdog_clk_sel),
      .wake_any      (wake_any),
      .settle_done   (settle_done),
      .ext_rst_n     (ext_rst_n),
      .hw_stdby_n    (hw_stdby_n),
      .mode          (mode),
      .settle_load   (settle_load),
      .settle_active (settle_active),
      .irq_exc_req   (irq_exc_req),
      .rst_exc_req   (rst_exc_req)
   );

   always_comb begin
      osc_en        = 1'b0;
      cpu_clk_en    = 1'b0;
      periph_clk_en = 1'b0;
      case (mode)
         PM_RUN, PM_RESET_WAIT: begin
            osc_en = 1'b1; cpu_clk_en = 1'b1; periph_clk_en = 1'b1;
         end
         PM_LIGHT: begin
            osc_en = 1'b1; periph_clk_en = 1'b1;
         end
         PM_SETTLE: osc_en = 1'b1;
         default: ;
      endcase
   end

   assign mode_o = mode;

   // R8: the reset exception is raised with the CPU clock already running
   a_r8_clock_before_reset_exc: assert property (@(posedge clk_ref) disable iff (!por_n)
      $rose(rst_exc_req) |-> ($past(cpu_clk_en) && cpu_clk_en));

   // R2: the CPU clock never runs in the cycle right after deep stop
   a_r2_no_clock_out_of_deep: assert property (@(posedge clk_ref) disable iff (!por_n)
      ($past(mode_o) == 3'd2 && ext_rst_n && $past(ext_rst_n)) |-> !cpu_clk_en);

endmodule

// File: tb/test_pwrdn_seq.sv
module test_pwrdn_seq;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sleep_req = 1'b0, standby_en = 1'b0, wdog_clk_sel = 1'b0;
   logic [2:0]  settle_sel = 3'd0;
   logic [15:0] irq_lines = '0, irq_en = '0;
   logic        irq_masked = 1'b0, nmi_pin = 1'b0, nmi_rise_sel = 1'b0;
   logic        resume_wake = 1'b0, ext_rst_n = 1'b1, hw_stdby_n = 1'b1;
   logic        osc_en, cpu_clk_en, periph_clk_en, irq_exc_req, rst_exc_req;
   logic [2:0]  mode_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pwrdn_seq i_pwrdn_seq (
      .clk_ref(clk), .por_n(por_n), .sleep_req(sleep_req), .standby_en(standby_en),
      .wdog_clk_sel(wdog_clk_sel), .settle_sel(settle_sel), .irq_lines(irq_lines),
      .irq_en(irq_en), .irq_masked(irq_masked), .nmi_pin(nmi_pin),
      .nmi_rise_sel(nmi_rise_sel), .resume_wake(resume_wake), .ext_rst_n(ext_rst_n),
      .hw_stdby_n(hw_stdby_n), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
      .periph_clk_en(periph_clk_en), .irq_exc_req(irq_exc_req),
      .rst_exc_req(rst_exc_req), .mode_o(mode_o)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clocks(input string tag, input int o, input int c, input int p);
      chk({tag, " osc_en"}, osc_en, o);
      chk({tag, " cpu_clk_en"}, cpu_clk_en, c);
      chk({tag, " periph_clk_en"}, periph_clk_en, p);
   endtask

   task automatic enter_deep();
      standby_en = 1; wdog_clk_sel = 0; sleep_req = 1;
      tick();
      sleep_req = 0;
      chk("R1 deep entry mode", mode_o, 2);
   endtask

   // called on the read right after the wake edge
   task automatic settle_wait(input int code, input string tag);
      int cnt = 0;
      int expv = 1 << (8 + code);
      chk({tag, " settle mode"}, mode_o, 3);
      clocks("R2 settling", 1, 0, 0);
      while (mode_o == 3 && cnt < 40000) begin
         cnt++;
         tick();
      end
      chk({tag, " R5 settle length"}, cnt, expv);
      chk("R5 run after settle", mode_o, 0);
      chk("R5 irq_exc_req pulse", irq_exc_req, 1);
      tick();
      chk("R5 irq_exc_req cleared", irq_exc_req, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(); tick(); tick();
      chk("reset mode", mode_o, 0);
      clocks("R2 reset clocks", 1, 1, 1);
      chk("reset irq_exc_req", irq_exc_req, 0);
      chk("reset rst_exc_req", rst_exc_req, 0);
      por_n = 1;
      tick();

      // R1 / R2: deep stop
      enter_deep();
      clocks("R2 deep", 0, 0, 0);
      tick(); tick();
      chk("R4 no wake stays deep", mode_o, 2);
      resume_wake = 1; tick(); resume_wake = 0;
      settle_wait(0, "R7 resume");

      // R3: light sleep with standby disabled
      standby_en = 0; sleep_req = 1; tick(); sleep_req = 0;
      chk("R3 light sleep mode", mode_o, 1);
      clocks("R3 light sleep", 1, 0, 1);
      tick();
      chk("R3 light sleep holds", mode_o, 1);
      irq_lines = 16'h0001; irq_en = 16'h0001; tick(); irq_lines = '0;
      chk("R3 immediate wake mode", mode_o, 0);
      chk("R3 irq_exc_req", irq_exc_req, 1);
      tick();
      chk("R3 irq_exc_req cleared", irq_exc_req, 0);

      // R3: watchdog clock select blocks deep stop
      standby_en = 1; wdog_clk_sel = 1; sleep_req = 1; tick(); sleep_req = 0;
      chk("R3 wdog select gives light sleep", mode_o, 1);
      resume_wake = 1; tick(); resume_wake = 0;
      chk("R3 resume from light sleep", mode_o, 0);
      chk("R3 irq_exc_req after resume", irq_exc_req, 1);
      wdog_clk_sel = 0; tick();

      // R4: sweep every line: disabled, masked, then qualified
      settle_sel = 3'd0;
      for (int n = 0; n < 16; n++) begin
         enter_deep();
         irq_masked = 0;
         irq_en = ~(16'h1 << n); irq_lines = 16'h1 << n;
         tick(); tick();
         chk($sformatf("R4 line %0d disabled", n), mode_o, 2);
         irq_en = 16'h1 << n; irq_masked = 1;
         tick(); tick();
         chk($sformatf("R4 line %0d masked", n), mode_o, 2);
         irq_masked = 0;
         tick();
         irq_lines = '0;
         settle_wait(0, $sformatf("R4 line %0d", n));
      end

      // R5: every settling code
      for (int c = 0; c < 8; c++) begin
         settle_sel = c[2:0];
         enter_deep();
         irq_lines = 16'h8000; irq_en = 16'h8000;
         tick();
         irq_lines = '0;
         settle_wait(c, $sformatf("R5 code %0d", c));
      end
      settle_sel = 3'd0;

      // R6: falling-edge select
      nmi_rise_sel = 0; nmi_pin = 0; tick();
      enter_deep();
      nmi_pin = 1; tick(); tick();
      chk("R6 rising ignored when falling selected", mode_o, 2);
      nmi_pin = 0; tick();
      settle_wait(0, "R6 falling edge");

      // R6: rising-edge select
      nmi_rise_sel = 1; nmi_pin = 1; tick();
      enter_deep();
      nmi_pin = 0; tick(); tick();
      chk("R6 falling ignored when rising selected", mode_o, 2);
      nmi_pin = 1; tick();
      settle_wait(0, "R6 rising edge");
      nmi_pin = 0; tick();

      // R8: reset pin from deep stop
      enter_deep();
      ext_rst_n = 0; tick();
      chk("R8 reset wait mode", mode_o, 4);
      clocks("R8 clocks at once", 1, 1, 1);
      tick(); tick(); tick();
      chk("R8 holds while pin low", mode_o, 4);
      ext_rst_n = 1; tick();
      chk("R8 run after release", mode_o, 0);
      chk("R8 rst_exc_req", rst_exc_req, 1);
      chk("R8 no irq_exc_req", irq_exc_req, 0);
      tick();
      chk("R8 rst_exc_req cleared", rst_exc_req, 0);

      // R8: reset pin during settling
      settle_sel = 3'd3;
      enter_deep();
      irq_lines = 16'h0010; irq_en = 16'h0010; tick(); irq_lines = '0;
      chk("R5 settling started", mode_o, 3);
      repeat (5) tick();
      ext_rst_n = 0; tick();
      chk("R8 reset overrides settling", mode_o, 4);
      ext_rst_n = 1; tick();
      chk("R8 run after settle abort", mode_o, 0);
      chk("R8 rst_exc_req after abort", rst_exc_req, 1);
      settle_sel = 3'd0;

      // R9 / R10: hardware standby from deep stop with competing wakes
      enter_deep();
      hw_stdby_n = 0; ext_rst_n = 0; irq_lines = 16'h0001; irq_en = 16'h0001;
      tick();
      irq_lines = '0;
      chk("R9 hw hold wins", mode_o, 5);
      clocks("R2 hw hold", 0, 0, 0);
      hw_stdby_n = 1; ext_rst_n = 1; tick(); tick();
      chk("R10 pin high with reset high stays", mode_o, 5);
      hw_stdby_n = 0; ext_rst_n = 0; tick(); tick();
      chk("R10 pin low stays", mode_o, 5);
      hw_stdby_n = 1; tick();
      chk("R10 exit to reset wait", mode_o, 4);
      ext_rst_n = 1; tick();
      chk("R10 run after reset release", mode_o, 0);
      chk("R10 rst_exc_req", rst_exc_req, 1);

      // R9: from RUN
      hw_stdby_n = 0; tick();
      chk("R9 from run", mode_o, 5);
      hw_stdby_n = 1; ext_rst_n = 0; tick();
      chk("R10 exit from run path", mode_o, 4);
      ext_rst_n = 1; tick();
      chk("R10 back to run", mode_o, 0);

      tick();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule